// File: doc/BRIEF.md
# SPI Real-Time-Clock Register Access Slave

This block is the serial front end of a small real-time-clock register file. It has sixteen 8-bit locations. A host reaches them over a four-wire SPI link. Chip select is active high and the clock idles low. The host changes MOSI on the rising clock edge and the slave samples it on the falling edge. The slave changes MISO on the rising edge as well, so the host samples it on the falling edge.

Each chip-select assertion opens with a command byte. That byte names a start register and picks one of four transfer kinds: burst or single, read or write. A burst walks through consecutive registers, so a full date and time (seconds through year, locations 0 to 6) moves as one consistent seven-byte group. The register array has no reset and is built so that it maps onto block RAM. The flags and the hour-format bit are kept in flip-flops next to the array.

The time-keeping core has two roles:
- It updates registers through its own write port.
- It sees every host access through registered read and write strobes.

The oscillator-stop and low-voltage conditions enter as inputs and latch into the status register. After each release of chip select, the slave refuses new transactions for a programmable recovery time.

Top module: `rtc_spi_slave`

## Requirements
- R1: The command byte carries the start address in bits 7:4 and the transfer kind in bits 3:2: 00 burst write, 01 burst read, 10 single write, 11 single read. Bits 1:0 have no effect.
- R2: A transfer counts only while `spi_cs` is high. Data is MSB first. MISO changes only after a rising SCLK edge, and MOSI is captured on the falling edge. MISO is low whenever no transaction is accepted.
- R3: A burst read returns consecutive registers, starting at the command address, in every data byte. The first data byte is fetched as soon as the command byte completes. `rd_stb` pulses once for each fetch: once at the end of the command and once after each data byte.
- R4: A burst write stores each data byte into consecutive registers. Each stored byte raises `wr_stb` for one cycle, with its address and data.
- R5: The burst address wraps from location 15 to location 0.
- R6: A single transfer handles exactly one data byte. Later bytes in the same assertion write nothing, and MISO stays low during them.
- R7: Bit 7 of location 0 (seconds) always reads as zero.
- R8: Location 15 is the status register. `osc_stop_in` sets bit 4 and `low_volt_in` sets bit 6, and both bits are sticky. A write to location 15 loads both bits from the written data, so writing zero clears them. `osc_stop_flag` and `low_volt_flag` mirror the two bits.
- R9: Bit 5 of a write to location 14 sets `mode_24h`, which selects 24-hour mode.
- R10: An assertion of `spi_cs` that begins within `RECOV_CYCLES` clocks of any release is ignored in full. It performs no write and drives MISO low.
- R11: After reset, `spi_miso`, `wr_stb`, `rd_stb`, `mode_24h` and both flags are low.
- R12: `core_we` writes `core_wdata` to `core_addr`. If a host write occurs in the same cycle, the host write takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| core_we | input | 1 | Time-keeping core write enable |
| core_addr | input | 4 | Core write address |
| core_wdata | input | 8 | Core write data |
| osc_stop_in | input | 1 | Oscillator-stop event, sets status bit 4 |
| low_volt_in | input | 1 | Low-voltage event, sets status bit 6 |
| wr_stb | output | 1 | Host write strobe toward the core |
| wr_addr | output | 4 | Address of the host write |
| wr_data | output | 8 | Data of the host write |
| rd_stb | output | 1 | Host read-fetch strobe toward the core |
| rd_addr | output | 4 | Address fetched for shifting out |
| mode_24h | output | 1 | 24-hour mode selected |
| osc_stop_flag | output | 1 | Sticky oscillator-stop status |
| low_volt_flag | output | 1 | Sticky low-voltage status |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- **Late first fetch.** If the first read byte were fetched after the command byte rather than at its end, the first read byte would come out shifted or stale.
- **Seconds bit 7.** If the seconds top bit leaked, the first byte of a time burst would read back with bit 7 set.
- **Address wrap.** A burst that starts at location 13 crosses the top of the map. A design that did not wrap would return the wrong byte after the status register.
- **Trailing bytes in single mode.** Extra bytes after a single write are sent to catch a design that keeps writing.
- **Early reassertion.** A second assertion arrives inside the recovery window. A design that accepted it would change a register the host later reads back.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;

  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BITCNT_W  = $clog2(BYTE_W);

  localparam logic [ADDR_W-1:0] ADDR_SEC  = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTL1 = 4'd14;
  localparam logic [ADDR_W-1:0] ADDR_CTL2 = 4'd15;

  localparam int unsigned BIT_SEC_TOP = 7;
  localparam int unsigned BIT_24H     = 5;
  localparam int unsigned BIT_OSC     = 4;
  localparam int unsigned BIT_LV      = 6;

  typedef enum logic [1:0] {
    XF_BURST_WR = 2'b00,
    XF_BURST_RD = 2'b01,
    XF_ONE_WR   = 2'b10,
    XF_ONE_RD   = 2'b11
  } xfer_mode_e;

endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/rtc_spi_shifter.sv
module rtc_spi_shifter
  import rtc_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              miso,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);

  logic [BYTE_W-1:0]   tx_sh;
  logic [BYTE_W-1:0]   rx_sh;
  logic [BITCNT_W-1:0] bit_cnt;

  // the byte including the bit captured on this falling edge
  assign byte_val  = {rx_sh[BYTE_W-2:0], mosi};
  assign byte_done = sclk_fall && (bit_cnt == BITCNT_W'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_cnt <= '0;
      miso    <= 1'b0;
    end else begin
      if (load) begin
        tx_sh <= load_data;
      end else if (sclk_rise) begin
        miso  <= tx_sh[BYTE_W-1];
        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
      if (sclk_fall) begin
        rx_sh   <= byte_val;
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rtc_spi_regfile.sv
module rtc_spi_regfile
  import rtc_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [BYTE_W-1:0] rdata,
  input  logic              osc_set,
  input  logic              lv_set,
  output logic              osc_flag,
  output logic              lv_flag,
  output logic              hour24
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] mem_q;
  logic [ADDR_W-1:0] raddr_q;

  // array without reset, synchronous read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      mem_q <= mem[raddr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raddr_q  <= '0;
      osc_flag <= 1'b0;
      lv_flag  <= 1'b0;
      hour24   <= 1'b0;
    end else begin
      if (re) begin
        raddr_q <= raddr;
      end
      osc_flag <= osc_set | ((we && waddr == ADDR_CTL2) ? wdata[BIT_OSC] : osc_flag);
      lv_flag  <= lv_set  | ((we && waddr == ADDR_CTL2) ? wdata[BIT_LV]  : lv_flag);
      if (we && waddr == ADDR_CTL1) begin
        hour24 <= wdata[BIT_24H];
      end
    end
  end

  always_comb begin
    rdata = mem_q;
    if (raddr_q == ADDR_SEC) begin
      rdata[BIT_SEC_TOP] = 1'b0;
    end
    if (raddr_q == ADDR_CTL2) begin
      rdata[BIT_OSC] = osc_flag;
      rdata[BIT_LV]  = lv_flag;
    end
  end

endmodule

// File: rtl/rtc_spi_slave.sv
module rtc_spi_slave
  import rtc_spi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RECOV_CYCLES = 15500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [BYTE_W-1:0] core_wdata,
  input  logic              osc_stop_in,
  input  logic              low_volt_in,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_stb,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              mode_24h,
  output logic              osc_stop_flag,
  output logic              low_volt_flag
);

  localparam int unsigned RC_W = $clog2(RECOV_CYCLES + 1);

  // ---------------- input synchronization and edges ----------------
  logic [2:0] pins_s;
  logic       cs_s, sclk_s, mosi_s, cs_q, sclk_q;

  rtc_spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_cs, spi_sclk, spi_mosi}),
    .q   (pins_s)
  );
  assign {cs_s, sclk_s, mosi_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  logic cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic active;
  assign cs_rise   = cs_s & ~cs_q;
  assign cs_fall   = ~cs_s & cs_q;
  assign sclk_rise = active & sclk_s & ~sclk_q;
  assign sclk_fall = active & ~sclk_s & sclk_q;

  // ---------------- recovery window and acceptance ----------------
  logic [RC_W-1:0] recov_cnt;
  logic            recov_idle, accept;
  assign recov_idle = (recov_cnt == '0);
  assign accept     = cs_rise && recov_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      recov_cnt <= '0;
      active    <= 1'b0;
    end else begin
      if (cs_fall) begin
        recov_cnt <= RC_W'(RECOV_CYCLES);
      end else if (!recov_idle) begin
        recov_cnt <= recov_cnt - 1'b1;
      end
      if (cs_fall) begin
        active <= 1'b0;
      end else if (accept) begin
        active <= 1'b1;
      end
    end
  end

  // ---------------- bit shifter ----------------
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic              fetch, fetch_q;
  logic [ADDR_W-1:0] fetch_addr;
  logic [BYTE_W-1:0] rf_rdata;

  rtc_spi_shifter i_shifter (
    .clk       (clk),
    .rst       (rst),
    .enable    (active),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi      (mosi_s),
    .load      (fetch_q),
    .load_data (rf_rdata),
    .miso      (spi_miso),
    .byte_done (byte_done),
    .byte_val  (byte_val)
  );

  // ---------------- transaction control ----------------
  logic              in_cmd, spent;
  xfer_mode_e        mode, cmd_mode;
  logic [ADDR_W-1:0] ptr, cmd_addr, ptr_next;
  logic              mode_is_wr, mode_is_single, cmd_is_rd;
  logic              host_we, data_byte;

  assign cmd_mode       = xfer_mode_e'(byte_val[3:2]);
  assign cmd_addr       = byte_val[BYTE_W-1:BYTE_W-ADDR_W];
  assign ptr_next       = ptr + ADDR_W'(1);
  assign mode_is_wr     = (mode == XF_BURST_WR) || (mode == XF_ONE_WR);
  assign mode_is_single = (mode == XF_ONE_WR) || (mode == XF_ONE_RD);
  assign cmd_is_rd      = (cmd_mode == XF_BURST_RD) || (cmd_mode == XF_ONE_RD);
  assign data_byte      = byte_done && !in_cmd && !spent;
  assign host_we        = data_byte && mode_is_wr;

  always_comb begin
    fetch      = 1'b0;
    fetch_addr = ptr_next;
    if (byte_done && in_cmd && cmd_is_rd) begin
      fetch      = 1'b1;
      fetch_addr = cmd_addr;
    end else if (data_byte && mode == XF_BURST_RD) begin
      fetch      = 1'b1;
      fetch_addr = ptr_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cmd  <= 1'b0;
      spent   <= 1'b0;
      mode    <= XF_BURST_WR;
      ptr     <= '0;
      fetch_q <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_stb  <= 1'b0;
      rd_addr <= '0;
    end else begin
      fetch_q <= fetch;
      wr_stb  <= host_we;
      rd_stb  <= fetch;
      if (accept) begin
        in_cmd <= 1'b1;
        spent  <= 1'b0;
      end else if (byte_done && in_cmd) begin
        in_cmd <= 1'b0;
        ptr    <= cmd_addr;
        mode   <= cmd_mode;
      end else if (data_byte) begin
        ptr <= ptr_next;
        if (mode_is_single) begin
          spent <= 1'b1;
        end
      end
      if (host_we) begin
        wr_addr <= ptr;
        wr_data <= byte_val;
      end
      if (fetch) begin
        rd_addr <= fetch_addr;
      end
    end
  end

  // ---------------- register file ----------------
  logic              rf_we;
  logic [ADDR_W-1:0] rf_waddr;
  logic [BYTE_W-1:0] rf_wdata;

  assign rf_we    = host_we | core_we;
  assign rf_waddr = host_we ? ptr : core_addr;
  assign rf_wdata = host_we ? byte_val : core_wdata;

  rtc_spi_regfile i_regfile (
    .clk      (clk),
    .rst      (rst),
    .we       (rf_we),
    .waddr    (rf_waddr),
    .wdata    (rf_wdata),
    .re       (fetch),
    .raddr    (fetch_addr),
    .rdata    (rf_rdata),
    .osc_set  (osc_stop_in),
    .lv_set   (low_volt_in),
    .osc_flag (osc_stop_flag),
    .lv_flag  (low_volt_flag),
    .hour24   (mode_24h)
  );

endmodule

// File: rtl/rtc_spi_checker.sv
module rtc_spi_checker
  import rtc_spi_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              active,
  input logic              recov_idle,
  input logic              sclk_rise,
  input logic              spi_miso,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic              rd_stb,
  input logic              osc_stop_in,
  input logic              low_volt_in,
  input logic              osc_stop_flag,
  input logic              low_volt_flag,
  input logic              mode_24h
);

  assert_miso_edge_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_miso) |-> ($past(sclk_rise) || !$past(active)));

  assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb);

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  assert_osc_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    osc_stop_in |=> osc_stop_flag);

  assert_lv_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    low_volt_in |=> low_volt_flag);

  assert_hour_fmt_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == ADDR_CTL1) |-> (mode_24h == wr_data[BIT_24H]));

  assert_accept_window_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(recov_idle));

  assert_write_needs_accept_R10: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(active));

endmodule

bind rtc_spi_slave rtc_spi_checker i_checker (
  .clk           (clk),
  .rst           (rst),
  .active        (active),
  .recov_idle    (recov_idle),
  .sclk_rise     (sclk_rise),
  .spi_miso      (spi_miso),
  .wr_stb        (wr_stb),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .rd_stb        (rd_stb),
  .osc_stop_in   (osc_stop_in),
  .low_volt_in   (low_volt_in),
  .osc_stop_flag (osc_stop_flag),
  .low_volt_flag (low_volt_flag),
  .mode_24h      (mode_24h)
);

// File: tb/test_rtc_spi_slave.sv
module test_rtc_spi_slave;

  localparam int RECOV = 100;
  localparam int HALF  = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_sclk = 1'b0, spi_cs = 1'b0, spi_mosi = 1'b0;
  logic       spi_miso;
  logic       core_we = 1'b0;
  logic [3:0] core_addr = '0;
  logic [7:0] core_wdata = '0;
  logic       osc_stop_in = 1'b0, low_volt_in = 1'b0;
  logic       wr_stb, rd_stb, mode_24h, osc_stop_flag, low_volt_flag;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rtc_spi_slave #(.SYNC_STAGES(2), .RECOV_CYCLES(RECOV)) i_rtc_spi_slave (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs(spi_cs), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .osc_stop_in(osc_stop_in), .low_volt_in(low_volt_in), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_addr(rd_addr), .mode_24h(mode_24h),
    .osc_stop_flag(osc_stop_flag), .low_volt_flag(low_volt_flag)
  );

  int         wr_seen = 0, rd_seen = 0;
  logic [3:0] wr_a_last = '0;
  logic [7:0] wr_d_last = '0;

  always @(posedge clk) begin
    if (wr_stb) begin
      wr_seen   <= wr_seen + 1;
      wr_a_last <= wr_addr;
      wr_d_last <= wr_data;
    end
    if (rd_stb) rd_seen <= rd_seen + 1;
  end

  logic [7:0] tx_buf [16];
  logic [7:0] rx_buf [16];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_xfer(input int n, input int gap);
    logic [7:0] r;
    spi_cs = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      r = '0;
      for (int i = 7; i >= 0; i--) begin
        spi_sclk = 1'b1;
        spi_mosi = tx_buf[b][i];
        repeat (HALF) @(negedge clk);
        r[i] = spi_miso;
        spi_sclk = 1'b0;
        repeat (HALF) @(negedge clk);
      end
      rx_buf[b] = r;
    end
    repeat (4) @(negedge clk);
    spi_cs = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic single_read(input logic [3:0] a, output logic [7:0] v);
    tx_buf[0] = {a, 4'b1100};
    tx_buf[1] = 8'h00;
    spi_xfer(2, RECOV + 20);
    v = rx_buf[1];
  endtask

  task automatic t_reset;
    chk("R11 miso", spi_miso, 0);
    chk("R11 wr_stb", wr_stb, 0);
    chk("R11 rd_stb", rd_stb, 0);
    chk("R11 mode_24h", mode_24h, 0);
    chk("R11 flags", {osc_stop_flag, low_volt_flag}, 0);
  endtask

  task automatic t_burst;
    int w0, r0;
    logic [7:0] exp [7];
    exp = '{8'h59, 8'h45, 8'h23, 8'h04, 8'h17, 8'h08, 8'h26};
    w0 = wr_seen;
    tx_buf[0] = 8'h00;
    tx_buf[1] = 8'hD9;
    for (int k = 1; k < 7; k++) tx_buf[k+1] = exp[k];
    spi_xfer(8, RECOV + 20);
    chk("R4 burst write strobes", wr_seen - w0, 7);
    chk("R4 last write addr", wr_a_last, 6);
    chk("R4 last write data", wr_d_last, 8'h26);
    r0 = rd_seen;
    tx_buf[0] = 8'h04;
    for (int k = 1; k < 8; k++) tx_buf[k] = 8'h00;
    spi_xfer(8, RECOV + 20);
    chk("R7 seconds bit7 reads zero", rx_buf[1], 8'h59);
    for (int k = 2; k < 8; k++) chk("R3 burst read byte", rx_buf[k], exp[k-1]);
    chk("R3 fetch strobes", rd_seen - r0, 8);
    chk("R2 miso idle low", spi_miso, 0);
  endtask

  task automatic t_single;
    int w0, r0;
    logic [7:0] v;
    tx_buf[0] = 8'h80;
    tx_buf[1] = 8'hA1; tx_buf[2] = 8'hA2; tx_buf[3] = 8'hA3; tx_buf[4] = 8'hA4;
    spi_xfer(5, RECOV + 20);
    w0 = wr_seen;
    tx_buf[0] = 8'h98; tx_buf[1] = 8'h5C; tx_buf[2] = 8'hEE; tx_buf[3] = 8'hFF;
    spi_xfer(4, RECOV + 20);
    chk("R6 single write one strobe", wr_seen - w0, 1);
    r0 = rd_seen;
    tx_buf[0] = 8'h9C; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
    spi_xfer(3, RECOV + 20);
    chk("R6 single read data", rx_buf[1], 8'h5C);
    chk("R6 trailing byte low", rx_buf[2], 8'h00);
    chk("R6 single read one fetch", rd_seen - r0, 1);
    single_read(4'd10, v);
    chk("R6 neighbour untouched", v, 8'hA3);
  endtask

  task automatic t_cmd_bits;
    tx_buf[0] = 8'h9F; tx_buf[1] = 8'h00;
    spi_xfer(2, RECOV + 20);
    chk("R1 low command bits ignored", rx_buf[1], 8'h5C);
  endtask

  task automatic t_wrap;
    tx_buf[0] = 8'hD0;
    tx_buf[1] = 8'h3C; tx_buf[2] = 8'h20; tx_buf[3] = 8'h00; tx_buf[4] = 8'h81;
    spi_xfer(5, RECOV + 20);
    chk("R9 24h mode set", mode_24h, 1);
    tx_buf[0] = 8'hD4;
    for (int k = 1; k < 5; k++) tx_buf[k] = 8'h00;
    spi_xfer(5, RECOV + 20);
    chk("R5 wrap byte 13", rx_buf[1], 8'h3C);
    chk("R5 wrap byte 14", rx_buf[2], 8'h20);
    chk("R5 wrap byte 15", rx_buf[3], 8'h00);
    chk("R5 wrap to 0", rx_buf[4], 8'h01);
    tx_buf[0] = 8'hE8; tx_buf[1] = 8'h00;
    spi_xfer(2, RECOV + 20);
    chk("R9 24h mode cleared", mode_24h, 0);
  endtask

  task automatic t_flags;
    logic [7:0] v;
    @(negedge clk) osc_stop_in = 1'b1;
    @(negedge clk) osc_stop_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 osc flag sticky", osc_stop_flag, 1);
    single_read(4'd15, v);
    chk("R8 status after osc", v, 8'h10);
    @(negedge clk) low_volt_in = 1'b1;
    @(negedge clk) low_volt_in = 1'b0;
    single_read(4'd15, v);
    chk("R8 status after low volt", v, 8'h50);
    tx_buf[0] = 8'hF8; tx_buf[1] = 8'h00;
    spi_xfer(2, RECOV + 20);
    chk("R8 flags cleared", {osc_stop_flag, low_volt_flag}, 0);
    single_read(4'd15, v);
    chk("R8 status cleared", v, 8'h00);
  endtask

  task automatic t_core;
    logic [7:0] v;
    @(negedge clk);
    core_we = 1'b1; core_addr = 4'd5; core_wdata = 8'h12;
    @(negedge clk);
    core_we = 1'b0;
    single_read(4'd5, v);
    chk("R12 core write visible", v, 8'h12);
  endtask

  task automatic t_recovery;
    int w0;
    logic [7:0] v;
    w0 = wr_seen;
    tx_buf[0] = 8'h88; tx_buf[1] = 8'h11;
    spi_xfer(2, 20);
    tx_buf[0] = 8'h98; tx_buf[1] = 8'h77;
    spi_xfer(2, RECOV + 20);
    chk("R10 only first write strobed", wr_seen - w0, 1);
    tx_buf[0] = 8'h8C; tx_buf[1] = 8'h00;
    spi_xfer(2, 20);
    chk("R10 accepted read", rx_buf[1], 8'h11);
    tx_buf[0] = 8'h9C; tx_buf[1] = 8'h00;
    spi_xfer(2, RECOV + 20);
    chk("R10 rejected read miso low", rx_buf[1], 8'h00);
    single_read(4'd9, v);
    chk("R10 rejected write had no effect", v, 8'h5C);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_burst();
    t_single();
    t_cmd_bits();
    t_wrap();
    t_flags();
    t_core();
    t_recovery();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule